// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block stands between a 32-bit register bus and a serial shift engine. It holds a byte-wide transmit queue and a byte-wide receive queue. The bus side writes whole 32-bit words into the transmit queue and drains the receive queue either a word or a byte at a time. The engine side takes transmit bytes one at a time and delivers received bytes one at a time. Byte order is big-endian: the most significant byte of a word is first on the wire.

Two event flags summarise queue state. Receive-not-empty fires when receive occupancy rises above a programmable threshold, or when the engine reports that the transaction has ended while bytes are still waiting. Transmit-not-full fires when transmit occupancy falls below its own programmable threshold. Each flag latches on the rising edge of its cause. It is cleared by writing a one to its bit, and it also drops by itself when the cause goes away. The event word also carries both live byte counts, so one read tells software how much to move. A mask register selects which pending flags drive the single interrupt line.

Top module: `spi_fifo_evt`

## Requirements
- R1: Registers sit at these offsets: mode 0x00, event 0x04, mask 0x08, transmit 0x10, receive 0x14. The mode register holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0, and resets to 4 and 3 (reads 0x0000_0403). The mask register keeps only bits 9 and 8 and resets to zero. Both read back what was written.
- R2: A write to the transmit register queues 4 bytes, bits 31:24 first and bits 7:0 last. The engine receives them in that order. Event bits 21:16 show the transmit byte count.
- R3: A transmit write is ignored when fewer than 4 bytes of space remain in the queue (the depth is 32 bytes).
- R4: Event bits 29:24 show the receive byte count. A word read (byte-select low) pops up to 4 bytes. The oldest byte is returned in bits 31:24, and lanes with no byte read as zero.
- R5: A byte read (byte-select high) pops one byte and returns it in bits 7:0, with the upper bits zero.
- R6: A read from an empty receive queue returns zero and leaves the counts unchanged.
- R7: Event bit 8 (transmit-not-full) becomes pending one cycle after transmit occupancy falls below the transmit threshold.
- R8: Event bit 9 (receive-not-empty) becomes pending one cycle after receive occupancy rises above the receive threshold. It also becomes pending when the transaction-end input is high and at least one byte is queued.
- R9: Writing the event register clears each pending bit written as one. Bits written as zero are unaffected. A cleared bit does not set again until its cause has gone away and returned.
- R10: A pending event drops one cycle after its cause goes away, with no write needed.
- R11: The interrupt output is high exactly when some event bit is both pending and enabled in the mask.
- R12: A received byte offered while the receive queue is full is dropped, and the ready output is low in that state. A transmit pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops only at the receive offset) |
| bus_byte | input | 1 | Receive read width: 1 = one byte, 0 = full word |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the offset) |
| irq | output | 1 | Interrupt: any pending event that is enabled in the mask |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_tx_avail | output | 1 | Transmit queue holds at least one byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Receive queue has room |
| eng_xfer_end | input | 1 | Engine reports the current transaction has ended |

## Verification
On every cycle the assertions check the following. Neither queue overflows or underflows. A refused transmit write, a read of an empty receive queue and a receive byte arriving at a full queue leave the counts alone. A byte read removes exactly one byte. A pending flag never exists without its cause on the previous cycle, and a write-one clear always removes it. The bench shows what no single-cycle property can: the byte order through both queues, the packing of the counts into the event word across full fill-and-drain sweeps, the re-arm behaviour after a clear, the threshold sweep and transaction-end case for the receive flag, and the interrupt following the mask.

// File: rtl/spi_fe_pkg.sv
// Shared constants for the SPI FIFO event unit: register offsets, field
// positions in the event/mode/mask words, and the bus lane count.
// Assumes a 32-bit big-endian register bus.
package spi_fe_pkg;
    localparam int LANES     = 4;     // bytes per bus word
    localparam int CNT_W     = 6;     // width of count and threshold fields
    localparam int OFF_MODE  = 'h00;
    localparam int OFF_EVT   = 'h04;
    localparam int OFF_MASK  = 'h08;
    localparam int OFF_TX    = 'h10;
    localparam int OFF_RX    = 'h14;
    localparam int BIT_NE    = 9;     // receive-not-empty event / mask bit
    localparam int BIT_NF    = 8;     // transmit-not-full event / mask bit
    localparam int RXC_LSB   = 24;    // receive count field in event word
    localparam int TXC_LSB   = 16;    // transmit count field in event word
    localparam int TXTHR_LSB = 8;     // transmit threshold in mode word
    localparam int RXTHR_LSB = 0;     // receive threshold in mode word
    localparam int EV_NF     = 0;     // index of transmit flag in flag vectors
    localparam int EV_NE     = 1;     // index of receive flag in flag vectors
    localparam int EV_N      = 2;     // number of event flags
endpackage

// File: rtl/sfe_byte_fifo.sv
// Byte queue with a multi-byte push port and a multi-byte peek/pop port.
// Lane 0 is the oldest byte and sits in the most significant byte position
// of both data ports. Assumes DEPTH is a power of two, that the caller never
// pushes more than the free space and never pops more than the count.
module sfe_byte_fifo #(
    parameter int DEPTH     = 32,
    parameter int IN_LANES  = 4,
    parameter int OUT_LANES = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(IN_LANES+1)-1:0]   push_n,
    input  logic [IN_LANES*8-1:0]           push_data,
    input  logic [$clog2(OUT_LANES+1)-1:0]  pop_n,
    output logic [OUT_LANES*8-1:0]          peek,
    output logic [$clog2(DEPTH+1)-1:0]      count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            cnt    <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    // Store the pushed lanes, oldest lane at the current write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < IN_LANES; i++) begin
            if (i < int'(push_n))
                mem[wr_ptr + AW'(i)] <= push_data[(IN_LANES-1-i)*8 +: 8];
        end
    end

    // Present the oldest OUT_LANES bytes.
    for (genvar g = 0; g < OUT_LANES; g++) begin : g_peek
        assign peek[(OUT_LANES-1-g)*8 +: 8] = mem[rd_ptr + AW'(g)];
    end

    assign count = cnt;

    // R3
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) + int'(push_n) <= DEPTH);
    // R6
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(cnt));
endmodule

// File: rtl/sfe_evt_flag.sv
// One latched event flag. It sets on the rising edge of its cause, clears on
// a write-one strobe, and drops by itself once the cause is gone. A clear
// while the cause persists holds until the cause falls and rises again.
module sfe_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic clr,
    output logic pending
);
    logic cause_q, pend_q;
    logic rise;

    assign rise = cause && !cause_q;

    // Track the cause one cycle back and update the latched flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            cause_q <= cause;
            pend_q  <= cause && ((pend_q && !clr) || rise);
        end
    end

    assign pending = pend_q;

    // R10
    flag_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $past(cause));
    // R9
    flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && clr) |=> !pending);
endmodule

// File: rtl/spi_fifo_evt.sv
// Register-side front end of an SPI controller: transmit and receive byte
// queues, threshold-driven event flags with write-one-to-clear, a mask and a
// single interrupt. Assumes the shift engine pops/pushes one byte per cycle
// at most, and that bus reads have no side effect except at the receive
// offset.
module spi_fifo_evt
    import spi_fe_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int ADDR_W     = 8,
    parameter int TX_THR_RST = 4,
    parameter int RX_THR_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              eng_tx_pop,
    output logic [7:0]        eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_data,
    output logic              eng_rx_ready,
    input  logic              eng_xfer_end
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int WW = $clog2(LANES+1);

    logic [CW-1:0]       tx_cnt, rx_cnt;
    logic [7:0]          tx_head;
    logic [LANES*8-1:0]  rx_peek;
    logic [WW-1:0]       tx_push_n, rx_pop_n;
    logic                tx_pop_n, rx_push_n;
    logic [CNT_W-1:0]    tx_thr, rx_thr;
    logic [EV_N-1:0]     mask_q, cause_v, clr_v, pend_v;
    logic                sel_mode, sel_evt, sel_mask, sel_tx, sel_rx;
    logic                tx_room, rx_rd;
    logic [31:0]         evt_word, rx_word;

    // Offset decode.
    assign sel_mode = bus_addr == ADDR_W'(OFF_MODE);
    assign sel_evt  = bus_addr == ADDR_W'(OFF_EVT);
    assign sel_mask = bus_addr == ADDR_W'(OFF_MASK);
    assign sel_tx   = bus_addr == ADDR_W'(OFF_TX);
    assign sel_rx   = bus_addr == ADDR_W'(OFF_RX);

    // Transmit side: whole-word pushes only when a full word fits.
    assign tx_room   = int'(tx_cnt) + LANES <= DEPTH;
    assign tx_push_n = (bus_wr && sel_tx && tx_room) ? WW'(LANES) : '0;
    assign tx_pop_n  = eng_tx_pop && (tx_cnt != '0);

    sfe_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(bus_wdata),
        .pop_n(tx_pop_n), .peek(tx_head), .count(tx_cnt)
    );

    assign eng_tx_data  = tx_head;
    assign eng_tx_avail = tx_cnt != '0;

    // Receive side: one byte in per cycle, up to a word out per read.
    assign rx_push_n    = eng_rx_valid && (int'(rx_cnt) != DEPTH);
    assign eng_rx_ready = int'(rx_cnt) != DEPTH;
    assign rx_rd        = bus_rd && sel_rx;

    // Pop count for a receive read: the requested width, capped by occupancy.
    always_comb begin
        int want;
        int take;
        want = bus_byte ? 1 : LANES;
        take = (int'(rx_cnt) < want) ? int'(rx_cnt) : want;
        rx_pop_n = rx_rd ? WW'(take) : '0;
    end

    sfe_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data(eng_rx_data),
        .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
    );

    // Receive read data: byte mode in the low lane, word mode zero-fills absent lanes.
    always_comb begin
        rx_word = '0;
        if (bus_byte) begin
            if (rx_cnt != '0)
                rx_word[7:0] = rx_peek[LANES*8-1 -: 8];
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(rx_cnt))
                    rx_word[(LANES-1-i)*8 +: 8] = rx_peek[(LANES-1-i)*8 +: 8];
            end
        end
    end

    // Mode (thresholds) and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= CNT_W'(TX_THR_RST);
            rx_thr <= CNT_W'(RX_THR_RST);
            mask_q <= '0;
        end else if (bus_wr) begin
            if (sel_mode) begin
                tx_thr <= bus_wdata[TXTHR_LSB +: CNT_W];
                rx_thr <= bus_wdata[RXTHR_LSB +: CNT_W];
            end
            if (sel_mask) begin
                mask_q[EV_NE] <= bus_wdata[BIT_NE];
                mask_q[EV_NF] <= bus_wdata[BIT_NF];
            end
        end
    end

    // Event causes and write-one clear strobes.
    assign cause_v[EV_NF] = CNT_W'(tx_cnt) < tx_thr;
    assign cause_v[EV_NE] = (CNT_W'(rx_cnt) > rx_thr) || (eng_xfer_end && rx_cnt != '0);
    assign clr_v[EV_NF]   = bus_wr && sel_evt && bus_wdata[BIT_NF];
    assign clr_v[EV_NE]   = bus_wr && sel_evt && bus_wdata[BIT_NE];

    for (genvar e = 0; e < EV_N; e++) begin : g_flag
        sfe_evt_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .cause(cause_v[e]), .clr(clr_v[e]), .pending(pend_v[e])
        );
    end

    assign irq = |(pend_v & mask_q);

    // Event word: live counts plus pending flags.
    always_comb begin
        evt_word = '0;
        evt_word[RXC_LSB +: CNT_W] = CNT_W'(rx_cnt);
        evt_word[TXC_LSB +: CNT_W] = CNT_W'(tx_cnt);
        evt_word[BIT_NE] = pend_v[EV_NE];
        evt_word[BIT_NF] = pend_v[EV_NF];
    end

    // Read data mux by offset.
    always_comb begin
        bus_rdata = '0;
        if (sel_mode) begin
            bus_rdata[TXTHR_LSB +: CNT_W] = tx_thr;
            bus_rdata[RXTHR_LSB +: CNT_W] = rx_thr;
        end else if (sel_evt) begin
            bus_rdata = evt_word;
        end else if (sel_mask) begin
            bus_rdata[BIT_NE] = mask_q[EV_NE];
            bus_rdata[BIT_NF] = mask_q[EV_NF];
        end else if (sel_rx) begin
            bus_rdata = rx_word;
        end
    end

    // R3
    tx_refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_tx && !tx_room && !eng_tx_pop) |=> tx_cnt == $past(tx_cnt));
    // R6
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_cnt == '0 && !eng_rx_valid) |=> rx_cnt == '0);
    // R5
    rx_byte_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && bus_byte && rx_cnt != '0 && !eng_rx_valid) |=> int'(rx_cnt) == int'($past(rx_cnt)) - 1);
    // R12
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && int'(rx_cnt) == DEPTH && !rx_rd) |=> int'(rx_cnt) == DEPTH);
    // R12
    tx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && tx_cnt == '0 && !(bus_wr && sel_tx)) |=> tx_cnt == '0);
endmodule

// File: tb/spi_fifo_evt_test.sv
// Self-checking bench: fill/drain sweeps of both queues, threshold sweep,
// clear/re-arm and mask checks, all expectations computed arithmetically.
module spi_fifo_evt_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_avail;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_ready;
    logic        eng_xfer_end = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_evt uut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
        .eng_xfer_end(eng_xfer_end)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic by, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a; bus_byte = by;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        eng_rx_valid = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic tx_out(output logic [7:0] b);
        b = eng_tx_data;
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    function automatic logic [31:0] txc(input logic [31:0] e); return {26'b0, e[21:16]}; endfunction
    function automatic logic [31:0] rxc(input logic [31:0] e); return {26'b0, e[29:24]}; endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        idle(3);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(8'h00, 1'b0, d); chk("R1 mode reset", d, 32'h0000_0403);
        bus_read(8'h08, 1'b0, d); chk("R1 mask reset", d, 32'h0);
        // R7 transmit flag set with empty queue below threshold 4
        bus_read(8'h04, 1'b0, d); chk("R7 event after reset", d, 32'h0000_0100);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);

        // R1 readback of only the defined fields
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, 1'b0, d); chk("R1 mode readback", d, 32'h0000_3F3F);
        bus_write(8'h00, 32'h0000_0403);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, 1'b0, d); chk("R1 mask readback", d, 32'h0000_0300);
        chk("R11 irq enabled", {31'b0, irq}, 32'h1);
        bus_write(8'h08, 32'h0);
        chk("R11 irq after unmask", {31'b0, irq}, 32'h0);

        // R2/R3 fill sweep: nine writes, the ninth refused
        for (int k = 1; k <= 9; k++) begin
            bus_write(8'h10, {8'(160+k), 8'(176+k), 8'(192+k), 8'(208+k)});
            bus_read(8'h04, 1'b0, d);
            chk(k == 9 ? "R3 refused write count" : "R2 tx count",
                txc(d), (4*k > 32) ? 32 : 4*k);
        end
        // R10 transmit flag dropped once occupancy reached threshold
        chk("R10 nf dropped", {31'b0, d[8]}, 32'h0);

        // R2 drain in big-endian order
        for (int j = 0; j < 32; j++) begin
            tx_out(b);
            chk("R2 tx byte order", {24'b0, b}, 32'(160 + 16*(j%4) + j/4 + 1));
        end
        chk("R12 avail empty", {31'b0, eng_tx_avail}, 32'h0);
        tx_out(b);
        idle(1);
        bus_read(8'h04, 1'b0, d);
        chk("R12 empty pop count", txc(d), 32'h0);
        chk("R7 nf set after drain", {31'b0, d[8]}, 32'h1);

        // R9 zero write has no effect, one write clears, no re-arm while cause holds
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, 1'b0, d); chk("R9 zero write keeps", {31'b0, d[8]}, 32'h1);
        bus_write(8'h08, 32'h0000_0100);
        chk("R11 irq nf", {31'b0, irq}, 32'h1);
        bus_write(8'h04, 32'h0000_0100);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
        idle(3);
        bus_read(8'h04, 1'b0, d); chk("R9 stays clear", {31'b0, d[8]}, 32'h0);
        // R9 re-arm: occupancy 4 then 3
        bus_write(8'h10, 32'h1122_3344);
        tx_out(b); chk("R2 single word b0", {24'b0, b}, 32'h11);
        idle(1);
        bus_read(8'h04, 1'b0, d); chk("R9 re-armed", {31'b0, d[8]}, 32'h1);
        chk("R11 irq re-armed", {31'b0, irq}, 32'h1);
        tx_out(b); chk("R2 single word b1", {24'b0, b}, 32'h22);
        tx_out(b); chk("R2 single word b2", {24'b0, b}, 32'h33);
        tx_out(b); chk("R2 single word b3", {24'b0, b}, 32'h44);
        bus_write(8'h08, 32'h0);

        // R4/R8/R12 receive fill sweep, one byte past full
        for (int n = 1; n <= 33; n++) begin
            rx_in(8'(n));
            idle(1);
            bus_read(8'h04, 1'b0, d);
            chk(n == 33 ? "R12 rx drop count" : "R4 rx count", rxc(d), (n > 32) ? 32 : n);
            chk("R8 ne by threshold", {31'b0, d[9]}, {31'b0, ((n > 32) ? 32 : n) > 3});
            chk("R12 rx ready", {31'b0, eng_rx_ready}, {31'b0, n < 32});
        end

        // R4 word read, R5 byte reads
        bus_read(8'h14, 1'b0, d); chk("R4 word read", d, 32'h0102_0304);
        bus_read(8'h14, 1'b1, d); chk("R5 byte read 5", d, 32'h5);
        bus_read(8'h14, 1'b1, d); chk("R5 byte read 6", d, 32'h6);
        bus_read(8'h04, 1'b0, d); chk("R4 count after reads", rxc(d), 32'd26);
        for (int w = 0; w < 6; w++) begin
            bus_read(8'h14, 1'b0, d);
            chk("R4 word sweep", d, {8'(7+4*w), 8'(8+4*w), 8'(9+4*w), 8'(10+4*w)});
        end
        bus_read(8'h14, 1'b0, d); chk("R4 partial word", d, 32'h1F20_0000);
        bus_read(8'h04, 1'b0, d);
        chk("R4 count zero", rxc(d), 32'h0);
        chk("R10 ne dropped", {31'b0, d[9]}, 32'h0);
        bus_read(8'h14, 1'b0, d); chk("R6 empty word", d, 32'h0);
        bus_read(8'h14, 1'b1, d); chk("R6 empty byte", d, 32'h0);
        bus_read(8'h04, 1'b0, d); chk("R6 counts unchanged", d & 32'h3F3F_0000, 32'h0);

        // R8 threshold sweep with two bytes queued, then transaction end
        rx_in(8'h5A);
        rx_in(8'hA5);
        for (int t = 0; t <= 3; t++) begin
            bus_write(8'h00, 32'h0000_0400 | 32'(t));
            idle(1);
            bus_read(8'h04, 1'b0, d);
            chk("R8 threshold sweep", {31'b0, d[9]}, {31'b0, 2 > t});
        end
        eng_xfer_end = 1'b1;
        idle(2);
        bus_read(8'h04, 1'b0, d); chk("R8 transaction end", {31'b0, d[9]}, 32'h1);
        bus_write(8'h08, 32'h0000_0200);
        chk("R11 irq ne", {31'b0, irq}, 32'h1);
        bus_read(8'h14, 1'b1, d); chk("R5 byte 5A", d, 32'h5A);
        bus_read(8'h14, 1'b1, d); chk("R5 byte A5", d, 32'hA5);
        idle(1);
        bus_read(8'h04, 1'b0, d); chk("R10 ne drop at empty", {31'b0, d[9]}, 32'h0);
        chk("R11 irq clear", {31'b0, irq}, 32'h0);
        eng_xfer_end = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule